// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A slow test clock and a mode-select input move a sixteen-state control machine through two parallel paths: one loads a six-bit instruction, the other moves data through the register that the instruction selects. Serial data enters on the data input and leaves on the data output. The output changes on the falling clock edge and is driven only while a shift is in progress.

The data side has three registers. A one-bit bypass register, a 32-bit identification register and a 32-bit user code register are each loaded with their fixed values during capture. Four user instructions each raise a one-hot select line, so that logic outside this block can act on them. While a user instruction is current, the serial path goes through the bypass bit.

There is no separate test-reset pin. A power-on reset sets the controller to its initial state. After that, the only way back is to drive the mode-select input high for five clock edges in a row.

Top module: `scan_port_ctrl`

## Requirements
- R1: All state changes take place on a rising `tck` edge. The next state depends only on the present state and the value of `tms` sampled at that edge, following the standard sixteen-state test-port graph.
- R2: From any state, five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset, even in the middle of a shift.
- R3: While `por_n` is low, the controller is held in Test-Logic-Reset with the identification instruction current, `tdo_en` = 0, `tdo` = 1 and `usr_sel` = 0.
- R4: In Capture-IR the instruction shift stage loads IR_CAPTURE (default 6'b000101), whose two low bits are 01. This pattern is the first thing shifted out in Shift-IR, least significant bit first.
- R5: In each shift state, the selected register moves one bit toward `tdo` on every rising edge, with `tdi` entering at the most significant end. The Pause states hold the contents unchanged.
- R6: The current instruction changes only on the falling edge while in Update-IR (it takes the shifted value) or in Test-Logic-Reset (it becomes the identification opcode). A Capture-DR reached directly from Update-IR through Select-DR-Scan uses the new instruction.
- R7: The opcodes are 6'b001001 for identification, 6'b001000 for user code and 6'b111111 for bypass. The four user instructions are 6'b000010, 6'b000011, 6'b100010 and 6'b100011. Any other opcode selects bypass.
- R8: Capture-DR loads bypass with 0, the identification register with ID_VALUE with bit 0 forced to 1, and the user code register with USER_CODE.
- R9: `tdo` and `tdo_en` change on the falling `tck` edge. `tdo_en` is 1 exactly in Shift-IR and Shift-DR. Outside those states `tdo` rests at 1.
- R10: `usr_sel[k]` is 1 exactly when user instruction k (in the order listed in R7) is current, so at most one bit is ever set. For user instructions, the serial data path is the one-bit bypass register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| usr_sel | output | 4 | One-hot select for the four user instructions |

## Verification
Two events can land close together. The instruction latch writes on a falling edge in Update-IR, and a data capture can follow only two rising edges later if the path goes straight through Select-DR-Scan. The bench forces this by leaving Update-IR with mode-select high and then reading the user code register, which only returns the right value if the capture used the freshly latched instruction. A second collision is a five-edge reset that cuts into a data shift under a user instruction. After it, the select lines must be clear and the identification value must read back. A long random walk on the mode-select input, compared edge by edge with a bench model, covers both collisions again at random points.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IR_W  = 6;
    localparam int N_USR = 4;

    typedef enum logic [3:0] {
        ST_EX2_DR = 4'h0, ST_EX1_DR = 4'h1, ST_SH_DR  = 4'h2, ST_PAU_DR = 4'h3,
        ST_SEL_IR = 4'h4, ST_UPD_DR = 4'h5, ST_CAP_DR = 4'h6, ST_SEL_DR = 4'h7,
        ST_EX2_IR = 4'h8, ST_EX1_IR = 4'h9, ST_SH_IR  = 4'hA, ST_PAU_IR = 4'hB,
        ST_RTI    = 4'hC, ST_UPD_IR = 4'hD, ST_CAP_IR = 4'hE, ST_TLR    = 4'hF
    } tap_state_e;

    typedef enum logic [1:0] {DR_BYP, DR_ID, DR_UC} dr_sel_e;

    localparam logic [IR_W-1:0] OP_IDCODE   = 6'b001001;
    localparam logic [IR_W-1:0] OP_USERCODE = 6'b001000;
    localparam logic [IR_W-1:0] OP_BYPASS   = 6'b111111;
    // user instructions, index 0 in the low slice
    localparam logic [N_USR*IR_W-1:0] OP_USER_PK =
        {6'b100011, 6'b100010, 6'b000011, 6'b000010};

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        unique case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.st = tap_next(fsm_q.st, tms);
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) fsm_q <= '{st: ST_TLR};
        else        fsm_q <= fsm_d;
    end

    assign state = fsm_q.st;

endmodule

// File: rtl/scan_ir.sv
module scan_ir
    import scan_pkg::*;
#(
    parameter logic [IR_W-1:0] IR_CAPTURE = 6'b000101
)(
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_shift,
    output logic [IR_W-1:0] ir_cur
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
    } ir_sh_t;

    typedef struct packed {
        logic [IR_W-1:0] cur;
    } ir_lat_t;

    ir_sh_t  sh_d,  sh_q;
    ir_lat_t lat_d, lat_q;

    // shift stage: rising edge
    always_comb begin
        sh_d = sh_q;
        if (state == ST_CAP_IR)
            sh_d.sh = IR_CAPTURE;
        else if (state == ST_SH_IR)
            sh_d.sh = {tdi, sh_q.sh[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) sh_q <= '{sh: IR_CAPTURE};
        else        sh_q <= sh_d;
    end

    // latch stage: falling edge
    always_comb begin
        lat_d = lat_q;
        if (state == ST_TLR)
            lat_d.cur = OP_IDCODE;
        else if (state == ST_UPD_IR)
            lat_d.cur = sh_q.sh;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) lat_q <= '{cur: OP_IDCODE};
        else        lat_q <= lat_d;
    end

    assign ir_shift = sh_q.sh;
    assign ir_cur   = lat_q.cur;

endmodule

// File: rtl/scan_dr.sv
module scan_dr
    import scan_pkg::*;
#(
    parameter int              DR_W      = 32,
    parameter logic [DR_W-1:0] ID_VALUE  = 32'h0A3C_5001,
    parameter logic [DR_W-1:0] USER_CODE = 32'h7E11_2D04
)(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_sel_e    sel,
    output logic       byp,
    output logic       dr_lsb
);

    localparam int N_WIDE = 2;
    localparam logic [DR_W-1:0] ID_CAP = {ID_VALUE[DR_W-1:1], 1'b1};

    typedef struct packed {
        logic                        byp;
        logic [N_WIDE-1:0][DR_W-1:0] wide;   // [0] identification, [1] user code
    } dr_t;

    dr_t dr_d, dr_q;
    logic [N_WIDE-1:0][DR_W-1:0] cap_val;
    logic [N_WIDE-1:0]           wide_hit;

    assign cap_val = {USER_CODE, ID_CAP};

    for (genvar g = 0; g < N_WIDE; g++) begin : g_hit
        assign wide_hit[g] = (sel == ((g == 0) ? DR_ID : DR_UC));
    end

    always_comb begin
        dr_d = dr_q;
        if (state == ST_CAP_DR) begin
            if (sel == DR_BYP) dr_d.byp = 1'b0;
            for (int i = 0; i < N_WIDE; i++)
                if (wide_hit[i]) dr_d.wide[i] = cap_val[i];
        end else if (state == ST_SH_DR) begin
            if (sel == DR_BYP) dr_d.byp = tdi;
            for (int i = 0; i < N_WIDE; i++)
                if (wide_hit[i]) dr_d.wide[i] = {tdi, dr_q.wide[i][DR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) dr_q <= '{byp: 1'b0, wide: {USER_CODE, ID_CAP}};
        else        dr_q <= dr_d;
    end

    always_comb begin
        dr_lsb = dr_q.byp;
        for (int i = 0; i < N_WIDE; i++)
            if (wide_hit[i]) dr_lsb = dr_q.wide[i][0];
    end

    assign byp = dr_q.byp;

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_pkg::*;
#(
    parameter int              DR_W       = 32,
    parameter logic [DR_W-1:0] ID_VALUE   = 32'h0A3C_5001,
    parameter logic [DR_W-1:0] USER_CODE  = 32'h7E11_2D04,
    parameter logic [IR_W-1:0] IR_CAPTURE = 6'b000101
)(
    input  logic             tck,
    input  logic             por_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    output logic [N_USR-1:0] usr_sel
);

    tap_state_e      st;
    logic [IR_W-1:0] ir_shift;
    logic [IR_W-1:0] ir_cur;
    dr_sel_e         dr_sel;
    logic            byp;
    logic            dr_lsb;

    typedef struct packed {
        logic tdo;
        logic en;
    } out_t;

    out_t out_d, out_q;

    scan_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (st)
    );

    scan_ir #(.IR_CAPTURE(IR_CAPTURE)) u_ir (
        .tck      (tck),
        .por_n    (por_n),
        .tdi      (tdi),
        .state    (st),
        .ir_shift (ir_shift),
        .ir_cur   (ir_cur)
    );

    scan_dr #(.DR_W(DR_W), .ID_VALUE(ID_VALUE), .USER_CODE(USER_CODE)) u_dr (
        .tck    (tck),
        .por_n  (por_n),
        .tdi    (tdi),
        .state  (st),
        .sel    (dr_sel),
        .byp    (byp),
        .dr_lsb (dr_lsb)
    );

    // instruction decode: unknown and user opcodes fall through to bypass
    always_comb begin
        dr_sel  = DR_BYP;
        usr_sel = '0;
        if (ir_cur == OP_IDCODE)        dr_sel = DR_ID;
        else if (ir_cur == OP_USERCODE) dr_sel = DR_UC;
        for (int k = 0; k < N_USR; k++)
            usr_sel[k] = (ir_cur == OP_USER_PK[k*IR_W +: IR_W]);
    end

    // serial output: falling edge
    always_comb begin
        out_d = '{tdo: 1'b1, en: 1'b0};
        if (st == ST_SH_IR)      out_d = '{tdo: ir_shift[0], en: 1'b1};
        else if (st == ST_SH_DR) out_d = '{tdo: dr_lsb,      en: 1'b1};
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) out_q <= '{tdo: 1'b1, en: 1'b0};
        else        out_q <= out_d;
    end

    assign tdo    = out_q.tdo;
    assign tdo_en = out_q.en;

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
    import scan_pkg::*;
#(
    parameter logic [IR_W-1:0] IR_CAPTURE = 6'b000101
)(
    input  logic             tck,
    input  logic             por_n,
    input  logic             tms,
    input  tap_state_e       state,
    input  logic [IR_W-1:0]  ir_shift,
    input  logic [IR_W-1:0]  ir_cur,
    input  dr_sel_e          dr_sel,
    input  logic             byp,
    input  logic             tdo,
    input  logic             tdo_en,
    input  logic [N_USR-1:0] usr_sel
);

    logic [2:0] hi_cnt_q;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)         hi_cnt_q <= '0;
        else if (!tms)      hi_cnt_q <= '0;
        else if (hi_cnt_q < 3'd5) hi_cnt_q <= hi_cnt_q + 3'd1;
    end

    assert_five_high_R2: assert property (@(posedge tck) disable iff (!por_n)
        (hi_cnt_q >= 3'd5) |-> (state == ST_TLR));

    assert_capture_ir_R4: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_IR) |=> (ir_shift == IR_CAPTURE));

    assert_latch_hold_R6: assert property (@(posedge tck) disable iff (!por_n)
        !(state == ST_UPD_IR || state == ST_TLR) |-> $stable(ir_cur));

    assert_tlr_idcode_R6: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_TLR) |-> (ir_cur == OP_IDCODE));

    assert_bypass_cap_R8: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_DR && dr_sel == DR_BYP) |=> (byp == 1'b0));

    assert_drive_window_R9: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en == (state == ST_SH_IR || state == ST_SH_DR));

    assert_idle_level_R9: assert property (@(posedge tck) disable iff (!por_n)
        !tdo_en |-> tdo);

    assert_usr_onehot_R10: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0(usr_sel));

endmodule

bind scan_port_ctrl scan_port_chk #(.IR_CAPTURE(IR_CAPTURE)) u_chk (
    .tck      (tck),
    .por_n    (por_n),
    .tms      (tms),
    .state    (st),
    .ir_shift (ir_shift),
    .ir_cur   (ir_cur),
    .dr_sel   (dr_sel),
    .byp      (byp),
    .tdo      (tdo),
    .tdo_en   (tdo_en),
    .usr_sel  (usr_sel)
);

// File: tb/scan_port_ctrl_tb.sv
module scan_port_ctrl_tb;

    localparam logic [31:0] ID_VAL  = 32'h1AB4_C093;
    localparam logic [31:0] UC_VAL  = 32'h5A5A_0F0F;
    localparam logic [5:0]  IR_CAP  = 6'b010001;
    localparam logic [5:0]  OP_ID   = 6'b001001;
    localparam logic [5:0]  OP_UC   = 6'b001000;
    localparam logic [5:0]  OP_BYP  = 6'b111111;
    localparam logic [23:0] OP_USR  = {6'b100011, 6'b100010, 6'b000011, 6'b000010};

    // bench-side state numbering
    localparam logic [3:0] S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHD = 4,
                           S_E1D = 5, S_PD = 6, S_E2D = 7, S_UDR = 8, S_SIR = 9,
                           S_CIR = 10, S_SHI = 11, S_E1I = 12, S_PI = 13, S_E2I = 14,
                           S_UIR = 15;

    logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en;
    logic [3:0] usr_sel;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    logic [3:0]  m_st  = S_TLR;
    logic [5:0]  m_ir  = IR_CAP;
    logic [5:0]  m_cur = OP_ID;
    logic        m_byp = 1'b0;
    logic [31:0] m_id  = ID_VAL;
    logic [31:0] m_uc  = UC_VAL;

    scan_port_ctrl #(.ID_VALUE(ID_VAL), .USER_CODE(UC_VAL), .IR_CAPTURE(IR_CAP)) u_dut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_en(tdo_en), .usr_sel(usr_sel)
    );

    always #5 tck = ~tck;

    function automatic logic [3:0] nx(input logic [3:0] s, input bit m);
        case (s)
            S_TLR: return m ? S_TLR : S_RTI;
            S_RTI: return m ? S_SDR : S_RTI;
            S_SDR: return m ? S_SIR : S_CDR;
            S_CDR: return m ? S_E1D : S_SHD;
            S_SHD: return m ? S_E1D : S_SHD;
            S_E1D: return m ? S_UDR : S_PD;
            S_PD:  return m ? S_E2D : S_PD;
            S_E2D: return m ? S_UDR : S_SHD;
            S_UDR: return m ? S_SDR : S_RTI;
            S_SIR: return m ? S_TLR : S_CIR;
            S_CIR: return m ? S_E1I : S_SHI;
            S_SHI: return m ? S_E1I : S_SHI;
            S_E1I: return m ? S_UIR : S_PI;
            S_PI:  return m ? S_E2I : S_PI;
            S_E2I: return m ? S_UIR : S_SHI;
            default: return m ? S_SDR : S_RTI;
        endcase
    endfunction

    function automatic logic [3:0] exp_usr(input logic [5:0] c);
        logic [3:0] r = '0;
        for (int k = 0; k < 4; k++) r[k] = (c == OP_USR[k*6 +: 6]);
        return r;
    endfunction

    function automatic logic exp_dr_bit();
        if (m_cur == OP_ID) return m_id[0];
        if (m_cur == OP_UC) return m_uc[0];
        return m_byp;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_edge(input bit m, input bit d);
        case (m_st)
            S_CIR: m_ir = IR_CAP;
            S_SHI: m_ir = {d, m_ir[5:1]};
            S_CDR: begin
                if (m_cur == OP_ID)      m_id  = ID_VAL;
                else if (m_cur == OP_UC) m_uc  = UC_VAL;
                else                     m_byp = 1'b0;
            end
            S_SHD: begin
                if (m_cur == OP_ID)      m_id  = {d, m_id[31:1]};
                else if (m_cur == OP_UC) m_uc  = {d, m_uc[31:1]};
                else                     m_byp = d;
            end
            default: ;
        endcase
        m_st = nx(m_st, m);
        if (m_st == S_UIR) m_cur = m_ir;
        if (m_st == S_TLR) m_cur = OP_ID;
    endtask

    // one test clock: sample after the falling edge, then drive for the next rising edge
    task automatic tick(input bit m, input bit d, output bit o);
        bit ee, eb;
        @(negedge tck); #2;
        ee = (m_st == S_SHD) || (m_st == S_SHI);
        chk(tdo_en === ee, "R9", "tdo_en", 32'(tdo_en), 32'(ee));
        chk(usr_sel === exp_usr(m_cur), "R10", "usr_sel", 32'(usr_sel), 32'(exp_usr(m_cur)));
        if (ee) begin
            eb = (m_st == S_SHI) ? m_ir[0] : exp_dr_bit();
            chk(tdo === eb, "R5", "tdo shift bit", 32'(tdo), 32'(eb));
        end else begin
            chk(tdo === 1'b1, "R9", "idle tdo", 32'(tdo), 32'd1);
        end
        o = tdo;
        tms = m; tdi = d;
        model_edge(m, d);
    endtask

    task automatic shift_ir(input logic [5:0] v, input bit to_sel, output logic [5:0] cap);
        bit o;
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 6; i++) begin
            tick(i == 5, v[i], o);
            cap[i] = o;
        end
        tick(1, 0, o);
        tick(to_sel, 0, o);
    endtask

    task automatic shift_dr(input int n, input logic [31:0] din, input bit from_sel,
                            output logic [31:0] dout);
        bit o;
        dout = '0;
        if (!from_sel) tick(1, 0, o);
        tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o);
            dout[i] = o;
        end
        tick(1, 0, o); tick(0, 0, o);
    endtask

    initial begin
        logic [5:0]  c;
        logic [31:0] d;
        bit o;

        // R3: held in reset
        #12;
        chk(tdo_en === 1'b0, "R3", "reset tdo_en", 32'(tdo_en), 32'd0);
        chk(tdo === 1'b1, "R3", "reset tdo", 32'(tdo), 32'd1);
        chk(usr_sel === 4'b0, "R3", "reset usr_sel", 32'(usr_sel), 32'd0);
        #11 por_n = 1'b1;

        tick(0, 0, o);
        // R3, R8: identification instruction current after power-up
        shift_dr(32, 32'h0, 0, d);
        chk(d === ID_VAL, "R3", "id after power-up", d, ID_VAL);

        // R4: capture pattern comes out first
        shift_ir(OP_BYP, 0, c);
        chk(c === IR_CAP, "R4", "ir capture", 32'(c), 32'(IR_CAP));
        chk(c[1:0] === 2'b01, "R4", "ir capture low bits", 32'(c[1:0]), 32'd1);

        // R7, R8: bypass delays by one bit, first bit is captured 0
        shift_dr(8, 32'hA5, 0, d);
        chk(d[7:0] === 8'h4A, "R7", "bypass stream", d, 32'h4A);

        // R6: Update-IR straight to Select-DR, capture uses new instruction
        shift_ir(OP_UC, 1, c);
        shift_dr(32, 32'h0, 1, d);
        chk(d === UC_VAL, "R6", "usercode after direct capture", d, UC_VAL);

        // R10: user selects and bypass routing
        for (int k = 0; k < 4; k++) begin
            shift_ir(OP_USR[k*6 +: 6], 0, c);
            chk(usr_sel === 4'(1 << k), "R10", "user select", 32'(usr_sel), 32'(1 << k));
            shift_dr(4, 32'hB, 0, d);
            chk(d[3:0] === 4'b0110, "R10", "user path is bypass", d, 32'h6);
        end

        // R7: undefined opcode acts as bypass
        shift_ir(6'b010101, 0, c);
        chk(usr_sel === 4'b0, "R7", "undefined usr_sel", 32'(usr_sel), 32'd0);
        shift_dr(4, 32'hD, 0, d);
        chk(d[3:0] === 4'b1010, "R7", "undefined as bypass", d, 32'hA);

        // R5: pause in the middle of an identification read
        shift_ir(OP_ID, 0, c);
        d = '0;
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 10; i++) begin tick(i == 9, 0, o); d[i] = o; end
        tick(0, 0, o); tick(0, 0, o); tick(0, 0, o); tick(0, 0, o);
        tick(1, 0, o); tick(0, 0, o);
        for (int i = 10; i < 32; i++) begin tick(i == 31, 0, o); d[i] = o; end
        tick(1, 0, o); tick(0, 0, o);
        chk(d === ID_VAL, "R5", "id across pause", d, ID_VAL);

        // R6: new instruction not visible before Update-IR
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 6; i++) tick(i == 5, OP_USR[6 + i], o);
        tick(1, 0, o);
        chk(usr_sel === 4'b0000, "R6", "usr_sel in Exit1-IR", 32'(usr_sel), 32'd0);
        tick(0, 0, o);
        chk(usr_sel === 4'b0010, "R6", "usr_sel after update", 32'(usr_sel), 32'd2);

        // R2: five high edges cut into a data shift
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o); tick(0, 1, o); tick(0, 1, o);
        for (int i = 0; i < 5; i++) tick(1, 0, o);
        tick(0, 0, o);
        chk(usr_sel === 4'b0, "R2", "usr_sel after tms reset", 32'(usr_sel), 32'd0);
        shift_dr(32, 32'h0, 0, d);
        chk(d === ID_VAL, "R2", "id after tms reset", d, ID_VAL);

        // R1: random walk compared edge by edge with the model
        void'($urandom(32'h5EED_0A11));
        for (int i = 0; i < 4000; i++)
            tick($urandom_range(0, 99) < 35, 1'($urandom_range(0, 1)), o);

        for (int i = 0; i < 5; i++) tick(1, 0, o);
        tick(1, 0, o);
        chk(m_st == S_TLR && usr_sel === 4'b0, "R1", "final reset walk", 32'(usr_sel), 32'd0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule